// File: doc/BRIEF.md
# IO Bank Freeze and Thaw Sequencer

This block moves a group of IO banks between a safe frozen condition and normal operation. Each bank gets a pad-control vector, and the block changes those vectors in a fixed order with timed gaps. The group holds `NB` identical simple banks, three by default, and one special bank. The special bank carries extra reset and calibration controls, so its thaw sequence is longer and includes two long waits for calibration to settle.

A single level input picks the target: 1 means frozen and 0 means thawed. When the level differs from the state the banks are settled in, the block runs the whole sequence for that direction. It works through the simple banks one at a time, starting at bank 0, and handles the special bank last. A 2-bit code reports whether the banks are settled frozen, settled thawed, or still moving. Every minimum gap is a parameter given in clock cycles, and each wait is counted exactly.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset every simple bank vector is 5'b00000, the special bank vector is 9'h0E0, and the state code is 2'b10.
- R2: Bit meanings per bank are bit0 config-done (high active), bit1 bus-hold, bit2 tristate, bit3 weak pull-up and bit4 slew. Bits 1 to 4 are active low. The special bank adds bit5 DLL reset, bit6 termination reset, bit7 regulator reset and bit8 calibration start. Settled thawed values are 5'b11111 for each simple bank and 9'h11F for the special bank.
- R3: The state code is 2'b10 when settled frozen, 2'b01 when settled thawed, and 2'b00 while a sequence runs.
- R4: Freezing a simple bank first clears bits 4, 3 and 2. Exactly GAP_SHORT cycles later it clears bits 1 and 0. Consecutive edits are GAP_SHORT cycles apart.
- R5: Freezing the special bank takes three edits, GAP_SHORT cycles apart. The first clears bits 4, 3 and 2. The second clears bits 1 and 0 and sets bits 7 and 6. The third clears bit 8 and sets bit 5.
- R6: Thawing a simple bank sets bits 1 and 0, then bits 3 and 2, then bit 4. The edits are GAP_SHORT cycles apart.
- R7: Thawing the special bank first clears bit 5. GAP_LONG cycles later it sets bit 8. WAIT_CAL cycles after that it sets bits 1 and 0 and clears bit 6. WAIT_OCT cycles later it sets bits 3 and 2. GAP_LONG cycles later it clears bit 7. GAP_LONG cycles later it sets bit 4.
- R8: In both directions, bank 0, then bank 1, then the remaining simple banks in order are fully sequenced before the special bank changes. The first edit of a sequence lands on the clock edge that sees the mismatching request.
- R9: A request change during a sequence is ignored until that sequence completes. A still-mismatching request then starts the opposite sequence one cycle later.
- R10: A request equal to the settled state causes no change on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze_req | input | 1 | Target level: 1 freeze, 0 thaw |
| simple_ctl | output | 5*NB | Simple bank vectors, bank b at bits [5b+4:5b] |
| special_ctl | output | 9 | Special bank vector |
| state | output | 2 | 10 frozen, 01 thawed, 00 sequencing |

## Verification
A wrong step index or gap counter shows up at the ports on the very clock where an edit lands early, late or on the wrong bank. The bench therefore compares every output against a behavioural queue of timed edits on every cycle, so a one-cycle timing slip is caught at once. A wrong settled flag shows up either as a state code that does not match the vectors, or as a spurious sequence that starts on a request which matches the settled state.

// File: rtl/io_freeze_seq.sv
module io_freeze_seq #(
  parameter int NB        = 3,
  parameter int GAP_SHORT = 5,
  parameter int GAP_LONG  = 10,
  parameter int WAIT_CAL  = 5000,
  parameter int WAIT_OCT  = 165
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            freeze_req,
  output logic [5*NB-1:0] simple_ctl,
  output logic [8:0]      special_ctl,
  output logic [1:0]      state
);
  localparam int SW       = 5;
  localparam int F_LAST   = 2*NB + 2;
  localparam int T_LAST   = 3*NB + 5;
  localparam int MAXG     = (WAIT_CAL > WAIT_OCT) ? WAIT_CAL : WAIT_OCT;
  localparam int CW       = $clog2(MAXG + 1) + 1;
  localparam int STW      = $clog2(T_LAST + 1) + 1;
  localparam logic [8:0] X_FROZEN = 9'h0E0;
  localparam logic [8:0] X_THAWED = 9'h11F;

  logic           busy, thawed, dir_q;
  logic [STW-1:0] step_q, cur_step;
  logic [CW-1:0]  cnt;
  logic           start, go, cur_dir;
  logic [5*NB-1:0] s_n;
  logic [8:0]     x_n;

  assign start    = !busy && (freeze_req == thawed);
  assign go       = start || (busy && cnt == '0);
  assign cur_dir  = busy ? dir_q : freeze_req;
  assign cur_step = busy ? step_q : '0;
  assign state    = busy ? 2'b00 : (thawed ? 2'b01 : 2'b10);

  function automatic int gap_before(input logic frz, input int s);
    if (frz) return GAP_SHORT;
    case (s - 3*NB)
      1, 4, 5: return GAP_LONG;
      2:       return WAIT_CAL;
      3:       return WAIT_OCT;
      default: return GAP_SHORT;
    endcase
  endfunction

  always_comb begin
    int st, bk;
    s_n = simple_ctl;
    x_n = special_ctl;
    st  = int'(cur_step);
    if (cur_dir) begin
      if (st < 2*NB) begin
        bk = st / 2;
        if (st % 2 == 0) s_n[bk*SW +: SW] = s_n[bk*SW +: SW] & 5'b00011;
        else             s_n[bk*SW +: SW] = s_n[bk*SW +: SW] & 5'b11100;
      end else begin
        case (st - 2*NB)
          0:       x_n = x_n & ~9'h01C;
          1:       x_n = (x_n & ~9'h003) | 9'h0C0;
          default: x_n = (x_n & ~9'h100) | 9'h020;
        endcase
      end
    end else begin
      if (st < 3*NB) begin
        bk = st / 3;
        case (st % 3)
          0:       s_n[bk*SW +: SW] = s_n[bk*SW +: SW] | 5'b00011;
          1:       s_n[bk*SW +: SW] = s_n[bk*SW +: SW] | 5'b01100;
          default: s_n[bk*SW +: SW] = s_n[bk*SW +: SW] | 5'b10000;
        endcase
      end else begin
        case (st - 3*NB)
          0:       x_n = x_n & ~9'h020;
          1:       x_n = x_n | 9'h100;
          2:       x_n = (x_n | 9'h003) & ~9'h040;
          3:       x_n = x_n | 9'h00C;
          4:       x_n = x_n & ~9'h080;
          default: x_n = x_n | 9'h010;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      simple_ctl  <= '0;
      special_ctl <= X_FROZEN;
      busy        <= 1'b0;
      thawed      <= 1'b0;
      dir_q       <= 1'b1;
      step_q      <= '0;
      cnt         <= '0;
    end else if (go) begin
      simple_ctl  <= s_n;
      special_ctl <= x_n;
      dir_q       <= cur_dir;
      if (int'(cur_step) == (cur_dir ? F_LAST : T_LAST)) begin
        busy   <= 1'b0;
        thawed <= !cur_dir;
      end else begin
        busy   <= 1'b1;
        step_q <= cur_step + 1'b1;
        cnt    <= CW'(gap_before(cur_dir, int'(cur_step) + 1) - 1);
      end
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  a_r1_reset_frozen: assert property (@(posedge clk)
    $rose(rst_n) |-> state == 2'b10 && simple_ctl == '0 && special_ctl == X_FROZEN);

  a_r2_frozen_vectors: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'b10 |-> simple_ctl == '0 && special_ctl == X_FROZEN);

  a_r2_thawed_vectors: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'b01 |-> simple_ctl == '1 && special_ctl == X_THAWED);

  a_r8_special_after_simple: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(special_ctl) |-> (simple_ctl == '0 || simple_ctl == '1));

  a_r10_no_activity_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b10 && freeze_req) |=> $stable(simple_ctl) && $stable(special_ctl));

  a_r10_no_activity_thawed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b01 && !freeze_req) |=> $stable(simple_ctl) && $stable(special_ctl));

  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);
endmodule

// File: tb/io_freeze_seq_tb.sv
module io_freeze_seq_tb;
  localparam int NB = 3, G_S = 5, G_L = 10, W_C = 5000, W_O = 165;

  logic clk = 0, rst_n = 0, freeze_req = 1;
  logic [5*NB-1:0] simple_ctl;
  logic [8:0] special_ctl;
  logic [1:0] state;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  io_freeze_seq #(.NB(NB), .GAP_SHORT(G_S), .GAP_LONG(G_L), .WAIT_CAL(W_C), .WAIT_OCT(W_O)) u_dut (
    .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req),
    .simple_ctl(simple_ctl), .special_ctl(special_ctl), .state(state));

  typedef struct { int gap; int bank; logic [8:0] clr; logic [8:0] set; } edit_t;
  edit_t q[$];
  logic [4:0] m_s [NB];
  logic [8:0] m_x;
  bit m_busy, m_thawed, m_dir;
  int since;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic void push(input int g, input int b, input logic [8:0] c, input logic [8:0] s);
    edit_t e;
    e.gap = g; e.bank = b; e.clr = c; e.set = s;
    q.push_back(e);
  endfunction

  function automatic void build(input bit frz);
    q.delete();
    if (frz) begin
      for (int b = 0; b < NB; b++) begin
        push(G_S, b, 9'h01C, 9'h000);
        push(G_S, b, 9'h003, 9'h000);
      end
      push(G_S, NB, 9'h01C, 9'h000);
      push(G_S, NB, 9'h003, 9'h0C0);
      push(G_S, NB, 9'h100, 9'h020);
    end else begin
      for (int b = 0; b < NB; b++) begin
        push(G_S, b, 9'h000, 9'h003);
        push(G_S, b, 9'h000, 9'h00C);
        push(G_S, b, 9'h000, 9'h010);
      end
      push(G_S, NB, 9'h020, 9'h000);
      push(G_L, NB, 9'h000, 9'h100);
      push(W_C, NB, 9'h040, 9'h003);
      push(W_O, NB, 9'h000, 9'h00C);
      push(G_L, NB, 9'h080, 9'h000);
      push(G_L, NB, 9'h000, 9'h010);
    end
  endfunction

  function automatic void apply_head();
    edit_t e = q.pop_front();
    if (e.bank < NB) m_s[e.bank] = (m_s[e.bank] & ~e.clr[4:0]) | e.set[4:0];
    else m_x = (m_x & ~e.clr) | e.set;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) m_s[b] = 5'b0;
      m_x = 9'h0E0; m_busy = 0; m_thawed = 0; m_dir = 1; since = 0;
    end else if (m_busy) begin
      since++;
      if (since == q[0].gap) begin
        apply_head();
        since = 0;
        if (q.size() == 0) begin m_busy = 0; m_thawed = !m_dir; end
      end
    end else if (freeze_req == m_thawed) begin
      m_dir = freeze_req;
      build(m_dir);
      apply_head();
      since = 0;
      m_busy = 1;
    end
  end

  logic [8:0] prev_x = 9'h0E0;
  logic [5*NB-1:0] prev_s = '0;
  int t_cal = 0, t_b0 = 0;
  always @(negedge clk) if (rst_n) begin
    logic [5*NB-1:0] es;
    logic [1:0] est;
    for (int b = 0; b < NB; b++) es[b*5 +: 5] = m_s[b];
    est = m_busy ? 2'b00 : (m_thawed ? 2'b01 : 2'b10);
    chk(simple_ctl == es, !m_busy ? "R10" : (m_dir ? "R4" : "R6"), 32'(simple_ctl), 32'(es));
    chk(special_ctl == m_x, !m_busy ? "R10" : (m_dir ? "R5" : "R7"), 32'(special_ctl), 32'(m_x));
    chk(state == est, "R3", 32'(state), 32'(est));
    if (special_ctl != prev_x && (prev_x == 9'h0E0 || prev_x == 9'h11F))
      chk(simple_ctl == '0 || simple_ctl == '1, "R8", 32'(simple_ctl), 32'h0);
    if (special_ctl[8] && !prev_x[8]) t_cal = cyc;
    if (special_ctl[0] && !prev_x[0])
      chk(cyc - t_cal == W_C, "R7", 32'(cyc - t_cal), 32'(W_C));
    if (!simple_ctl[4] && prev_s[4]) t_b0 = cyc;
    if (!simple_ctl[1] && prev_s[1])
      chk(cyc - t_b0 == G_S, "R4", 32'(cyc - t_b0), 32'(G_S));
    prev_x = special_ctl;
    prev_s = simple_ctl;
  end

  task automatic wait_state(input logic [1:0] s, input string tag);
    int n = 0;
    @(negedge clk);
    while (state != s && n < 20000) begin @(negedge clk); n++; end
    chk(state == s, tag, 32'(state), 32'(s));
  endtask

  task automatic hold_quiet(input int n, input string tag);
    logic [5*NB-1:0] s0 = simple_ctl;
    logic [8:0] x0 = special_ctl;
    repeat (n) @(negedge clk);
    chk(simple_ctl == s0 && special_ctl == x0, tag, 32'(special_ctl), 32'(x0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(state == 2'b10, "R1", 32'(state), 32'h2);
    chk(simple_ctl == '0, "R1", 32'(simple_ctl), 32'h0);
    chk(special_ctl == 9'h0E0, "R1", 32'(special_ctl), 32'h0E0);
    hold_quiet(40, "R10");
    freeze_req = 0;
    repeat (20) @(negedge clk);
    chk(state == 2'b00, "R3", 32'(state), 32'h0);
    wait_state(2'b01, "R3");
    chk(simple_ctl == '1, "R2", 32'(simple_ctl), 32'h7FFF);
    chk(special_ctl == 9'h11F, "R2", 32'(special_ctl), 32'h11F);
    hold_quiet(30, "R10");
    freeze_req = 1;
    repeat (10) @(negedge clk);
    freeze_req = 0;
    wait_state(2'b10, "R9");
    chk(special_ctl == 9'h0E0, "R9", 32'(special_ctl), 32'h0E0);
    @(negedge clk);
    chk(state == 2'b00, "R9", 32'(state), 32'h0);
    wait_state(2'b01, "R9");
    freeze_req = 1;
    wait_state(2'b10, "R5");
    chk(simple_ctl == '0, "R4", 32'(simple_ctl), 32'h0);
    hold_quiet(20, "R10");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule